// File: doc/BRIEF.md
# Selectable Multistage Audio Interpolator

This block takes a single channel of signed audio samples and raises it to a fixed intermediate rate. That rate is one sixteenth of the modulator clock-enable rate. The block chains up to three rate-doubling stages. Each active stage alternates between two kinds of output. On one step it emits an incoming sample unchanged. On the next step it emits a point computed between two neighbouring samples by a short half-band kernel. The run-time rate selection chooses how many of the stages are in use. One setting serves the lowest input rate, which needs three doublings. The other settings serve double and quadruple that rate. In every case the cascade delivers samples at the same output rate.

A zero-order hold follows the cascade. It presents each cascade result on the output for sixteen modulator ticks. The block never uses absolute frequencies. All of its timing comes from the `tick_mod` clock enable, so the block works for any master clock.

The producer writes samples into a one-entry hold register with `in_valid`. The cascade reads that register whenever its first active stage needs a new sample. The rate selection is captured only when a synchronous clear is applied, and that clear also empties every filter history.

Top module: `audio_interp_cascade`

## Requirements
- R1: An active doubling stage outputs its input samples unchanged, one after another. Between two consecutive samples b then c, it inserts the value floor((-a + 9b + 9c - d)/16). Here a is the sample before b and d is the sample after c.
- R2: The interpolated value saturates. It is clamped to the range -2^(SAMPLE_W-1) to 2^(SAMPLE_W-1)-1 and never wraps.
- R3: The captured rate code sets the number of active stages. Code 0 selects three stages, code 1 selects two, and codes 2 and 3 both select one. With N active stages, a new input sample is consumed on every 2^N-th cascade step, and the first such step comes right after a clear.
- R4: A cascade step occurs on the first `tick_mod` after reset or clear, and then on every sixteenth tick after that. `out_sample` takes the new cascade value at the clock edge of that step and does not change between steps.
- R5: `out_strobe` is high for exactly one cycle, in the cycle after each `tick_mod` that is not cancelled by `sync_clr`.
- R6: Inactive stages are the earliest in the chain. They pass data through without adding a register, so with one active stage the output is that single stage's response to the held input.
- R7: `rate_sel` is ignored unless `sync_clr` is high. A clear zeroes the histories, phases, tick count, hold register and output, and it loads `rate_sel`.
- R8: After reset, `out_sample` and `out_strobe` are 0 and the rate code is 0.
- R9: `in_valid` loads `in_sample` into the hold register, and a consume step reads the most recent sample written before it. A constant input therefore settles to the same constant at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of all histories; captures `rate_sel` |
| rate_sel | input | MODE_W | Rate code: 0 selects three stages, 1 two, 2 or 3 one |
| tick_mod | input | 1 | Clock enable at the modulator rate |
| in_valid | input | 1 | Loads `in_sample` into the hold register |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_sample | output | SAMPLE_W | Held cascade output (zero-order hold) |
| out_strobe | output | 1 | One-cycle pulse after each modulator tick |

## Verification
The output is compared every clock against a behavioural model, using several input patterns.

- A pseudo-random ramp in three-stage mode checks that samples are ordered correctly through the whole cascade.
- Two-stage mode runs with ticks arriving only every third clock. This shows that the take spacing and the hold length follow the tick count, not the clock count.
- Full-scale square steps in single-stage mode push the interpolated value past full scale at both polarities, so any wrap shows up against the clamp.
- Code 3 checks the reserved code, and a `rate_sel` change without a clear checks that the mode is held.
- A constant input tells a correct tap sum apart from a wrong gain.

// File: rtl/interp_pkg.sv
package interp_pkg;
    localparam int HIST_LEN   = 4;   // taps that reach the interpolated phase
    localparam int EXT_BITS   = 6;   // headroom for the 20x worst-case tap sum
    localparam int FRAC_SHIFT = 4;   // kernel scaled by 16
    localparam int CENTRE_MUL = 9;   // inner tap weight (outer tap weight is -1)

    typedef enum logic {
        PH_CONSUME = 1'b0,
        PH_INTERP  = 1'b1
    } hb_phase_e;
endpackage

// File: rtl/hb_stage.sv
module hb_stage
    import interp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                active,
    input  logic                step,
    input  logic signed [W-1:0] in_s,
    output logic signed [W-1:0] out_s,
    output logic                take
);
    localparam int AW = W + EXT_BITS;
    localparam logic signed [AW-1:0] MAXV = {{(EXT_BITS+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = {{(EXT_BITS+1){1'b1}}, {(W-1){1'b0}}};

    typedef struct packed {
        logic [HIST_LEN-1:0][W-1:0] hist;   // [0] newest
        hb_phase_e                  ph;
    } st_t;

    st_t st_d, st_q;

    function automatic logic signed [AW-1:0] ext(input logic [W-1:0] v);
        return $signed({{EXT_BITS{v[W-1]}}, v});
    endfunction

    logic signed [AW-1:0] acc, shifted;
    logic signed [W-1:0]  mid;

    always_comb begin
        acc = CENTRE_MUL * ext(st_q.hist[2]) + CENTRE_MUL * ext(st_q.hist[1])
              - ext(st_q.hist[3]) - ext(st_q.hist[0]);
        shifted = acc >>> FRAC_SHIFT;
        if (shifted > MAXV)      mid = MAXV[W-1:0];
        else if (shifted < MINV) mid = MINV[W-1:0];
        else                     mid = shifted[W-1:0];

        st_d  = st_q;
        take  = 1'b0;
        out_s = in_s;
        if (active) begin
            if (st_q.ph == PH_CONSUME) begin
                out_s = $signed(st_q.hist[1]);
                if (step) begin
                    take       = 1'b1;
                    st_d.hist  = {st_q.hist[HIST_LEN-2:0], in_s};
                    st_d.ph    = PH_INTERP;
                end
            end else begin
                out_s = mid;
                if (step) st_d.ph = PH_CONSUME;
            end
        end else begin
            take = step;
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: an emitted original sample is the one that moves to the centre slot
    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !clr && st_q.ph == PH_CONSUME)
        |=> ($signed(st_q.hist[2]) == $past(out_s)));
endmodule

// File: rtl/zoh_timebase.sv
module zoh_timebase #(
    parameter int ZOH_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic step,
    output logic strobe
);
    localparam int CW = (ZOH_LEN > 1) ? $clog2(ZOH_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(ZOH_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strobe;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d        = tb_q;
        step        = tick && !clr && (tb_q.cnt == '0);
        tb_d.strobe = tick && !clr;
        if (tick) tb_d.cnt = (tb_q.cnt == LAST) ? '0 : tb_q.cnt + 1'b1;
        if (clr)  tb_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign strobe = tb_q.strobe;

    // R4: a clear restarts the hold window so the next tick is a step
    assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tb_q.cnt == '0));
endmodule

// File: rtl/audio_interp_cascade.sv
module audio_interp_cascade
    import interp_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int STAGES   = 3,
    parameter int MODE_W   = 2,
    parameter int ZOH_LEN  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync_clr,
    input  logic [MODE_W-1:0]          rate_sel,
    input  logic                       tick_mod,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic signed [SAMPLE_W-1:0] out_sample,
    output logic                       out_strobe
);
    localparam int CHK_W = STAGES + 2;

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] outv;
    } top_t;

    top_t r_d, r_q;

    logic                       cas_step;
    logic [STAGES-1:0]          active;
    logic [STAGES-1:0]          stg_step;
    logic [STAGES-1:0]          stg_take;
    logic signed [SAMPLE_W-1:0] stg_in  [STAGES];
    logic signed [SAMPLE_W-1:0] stg_out [STAGES];
    int                         n_act;

    zoh_timebase #(.ZOH_LEN(ZOH_LEN)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sync_clr),
        .tick   (tick_mod),
        .step   (cas_step),
        .strobe (out_strobe)
    );

    always_comb begin
        n_act = STAGES - int'(r_q.mode);
        if (n_act < 1) n_act = 1;
        for (int i = 0; i < STAGES; i++) active[i] = (i >= STAGES - n_act);
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == STAGES - 1) begin : g_last
                assign stg_step[g] = cas_step;
            end else begin : g_mid
                assign stg_step[g] = stg_take[g+1];
            end
            if (g == 0) begin : g_first
                assign stg_in[g] = $signed(r_q.hold);
            end else begin : g_chain
                assign stg_in[g] = stg_out[g-1];
            end
            hb_stage #(.W(SAMPLE_W)) u_hb (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (sync_clr),
                .active (active[g]),
                .step   (stg_step[g]),
                .in_s   (stg_in[g]),
                .out_s  (stg_out[g]),
                .take   (stg_take[g])
            );
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (cas_step) r_d.outv = stg_out[STAGES-1];
        if (in_valid) r_d.hold = in_sample;
        if (sync_clr) begin
            r_d      = '0;
            r_d.mode = rate_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_sample = $signed(r_q.outv);

    // checker: cascade steps since the last clear
    logic [CHK_W-1:0] chk_steps_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chk_steps_q <= '0;
        else if (sync_clr) chk_steps_q <= '0;
        else if (cas_step) chk_steps_q <= chk_steps_q + 1'b1;
    end

    assert_take_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cas_step |-> (stg_take[0] ==
            ((chk_steps_q & CHK_W'((1 << n_act) - 1)) == '0)));

    assert_hold_between_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cas_step) && !$past(sync_clr)) |-> $stable(out_sample));

    assert_strobe_follows_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> $past(tick_mod));

    assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_clr) |-> $stable(r_q.mode));
endmodule

// File: tb/tb_audio_interp_cascade.sv
module tb_audio_interp_cascade;
    localparam int W  = 16;
    localparam int NS = 3;
    localparam int ZL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_clr = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic tick_mod = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic signed [W-1:0] out_sample;
    logic out_strobe;

    always #2 clk = ~clk;   // 250 MHz

    audio_interp_cascade dut (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .rate_sel(rate_sel),
        .tick_mod(tick_mod), .in_valid(in_valid), .in_sample(in_sample),
        .out_sample(out_sample), .out_strobe(out_strobe)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_mode = 0, m_hold = 0, m_out = 0, m_cnt = 0, m_strobe = 0;
    int mh [NS][4];
    int mph [NS];
    int seen_max, seen_min;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_clear(input int mode);
        m_mode = mode; m_hold = 0; m_out = 0; m_cnt = 0; m_strobe = 0;
        for (int i = 0; i < NS; i++) begin
            mph[i] = 0;
            for (int k = 0; k < 4; k++) mh[i][k] = 0;
        end
    endtask

    task automatic model_edge(input bit v, input int s, input bit tk, input bit cl, input int rs);
        int n, x, y;
        bit act [NS];
        bit st [NS];
        bit step;
        if (cl) begin
            model_clear(rs);
            return;
        end
        m_strobe = tk;
        step = tk && (m_cnt == 0);
        if (tk) m_cnt = (m_cnt + 1) % ZL;
        if (step) begin
            n = NS - m_mode;
            if (n < 1) n = 1;
            for (int i = 0; i < NS; i++) act[i] = (i >= NS - n);
            st[NS-1] = 1;
            for (int i = NS - 2; i >= 0; i--) st[i] = st[i+1] && (!act[i+1] || mph[i+1] == 0);
            x = m_hold;
            for (int i = 0; i < NS; i++) begin
                y = x;
                if (act[i] && st[i]) begin
                    if (mph[i] == 0) begin
                        y = mh[i][1];
                        mh[i][3] = mh[i][2]; mh[i][2] = mh[i][1]; mh[i][1] = mh[i][0];
                        mh[i][0] = x;
                        mph[i] = 1;
                    end else begin
                        y = sat((9*mh[i][2] + 9*mh[i][1] - mh[i][3] - mh[i][0]) >>> 4);
                        mph[i] = 0;
                    end
                end
                x = y;
            end
            m_out = x;
        end
        if (v) m_hold = s;
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit v, input int s, input bit tk, input bit cl, input int rs);
        in_valid = v; in_sample = W'(s); tick_mod = tk; sync_clr = cl; rate_sel = 2'(rs);
        @(posedge clk);
        model_edge(v, s, tk, cl, rs);
        @(negedge clk);
        check(out_sample == W'(m_out), {cur_req, " out_sample vs model"}, out_sample, m_out);
        check(out_strobe == m_strobe[0], {cur_req, " R5 out_strobe"}, out_strobe, m_strobe);
        if (out_sample > seen_max) seen_max = out_sample;
        if (out_sample < seen_min) seen_min = out_sample;
    endtask

    function automatic int ramp(input int k);
        return ((k * 3001) % 60000) - 30000;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        model_clear(0);
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_sample == 0, "R8 reset out_sample", out_sample, 0);
        check(out_strobe == 0, "R8 reset out_strobe", out_strobe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: mode after reset is three stages (no clear applied)
        cur_req = "R8";
        for (int k = 0; k < 400; k++) cyc(k % 29 == 0, ramp(k), 1, 0, 0);

        // R1 / R6: three stages, ramp, tick every clock
        cur_req = "R1";
        cyc(0, 0, 0, 1, 0);
        for (int k = 0; k < 2500; k++) cyc(k % 37 == 0, ramp(k + 5), 1, 0, 0);

        // R3 / R4: two stages, tick every third clock
        cur_req = "R3";
        cyc(0, 0, 0, 1, 1);
        for (int k = 0; k < 3000; k++) cyc(k % 53 == 0, ramp(k + 11), (k % 3) == 0, 0, 1);

        // R2: single stage, full-scale square steps
        cur_req = "R2";
        cyc(0, 0, 0, 1, 2);
        seen_max = -100000; seen_min = 100000;
        for (int k = 0; k < 3200; k++) cyc(1, ((k / 200) % 2) ? -32768 : 32767, 1, 0, 2);
        check(seen_max == 32767, "R2 positive clamp reached", seen_max, 32767);
        check(seen_min == -32768, "R2 negative clamp reached", seen_min, -32768);

        // R6: reserved code 3 acts as a single active stage
        cur_req = "R6";
        cyc(0, 0, 0, 1, 3);
        for (int k = 0; k < 1500; k++) cyc(k % 19 == 0, ramp(k + 77), 1, 0, 3);

        // R7: rate_sel change without clear is ignored
        cur_req = "R7";
        for (int k = 0; k < 1500; k++) cyc(k % 23 == 0, ramp(k + 301), 1, 0, 0);

        // R9: constant input settles to the same constant (three stages)
        cur_req = "R9";
        cyc(0, 0, 0, 1, 0);
        for (int k = 0; k < 3000; k++) cyc(1, 1000, 1, 0, 0);
        check(out_sample == 1000, "R9 DC settles", out_sample, 1000);

        summary();
    end
endmodule